// File: doc/BRIEF.md
# Activity-Steered Pin Bank Controller

This block runs a bank of general-purpose pins (eleven by default) for a radio. For each pin it selects the driven level from one of two places. The first is a register that software writes. The second is one of four activity registers. The radio's live receive and transmit status picks which activity register applies. So with no software action a pin can mark idle, receive-only, transmit-only or full-duplex operation. Software also decides, pin by pin, whether the pad is driven, and can read the true pad levels back through a two-flop synchroniser. That readback supports external loopback checks.

Every register write carries a value and a bit mask. Only the bits with a mask bit of 1 are updated. One shared address selects the register for both reads and writes. A read returns its data one clock after the request.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is undriven (`pinOutEn` = 0), every pin takes its level from the software register, and the source-select, direction, software-level and four activity registers all read back as 0.
- R2: A write changes exactly those bits of the addressed register whose `busWrMask` bit is 1. Every other bit keeps its previous value, and a mask of 0 changes nothing.
- R3: `pinOutEn[i]` equals bit i of the direction register (address 1). A 1 means the pin is driven.
- R4: A pin whose source-select bit (address 0) is 0 drives bit i of the software-level register (address 6), whatever the receive/transmit status is.
- R5: A pin whose source-select bit is 1 drives bit i of an activity register chosen by {`txBusy`,`rxBusy`}: 00 selects address 2 (idle), 01 selects address 3 (receive only), 10 selects address 4 (transmit only), 11 selects address 5 (full duplex).
- R6: A change on `rxBusy` or `txBusy` reaches `pinOutData` exactly one clock later.
- R7: The register map is: 0 source select, 1 direction, 2 to 5 activity registers, 6 software level, 7 pad readback. A read request sampled at one edge puts the register value on `busRdData` at that edge, and `busRdData` holds its value while no read is requested.
- R8: A read of address 7 returns `pinIn` as it was two clocks earlier, for every pin whatever its direction.
- R9: A write to address 7 has no effect on any register or pin output.
- R10: A read and a write to the same address in one cycle return the value from before the write.
- R11: A register write shows on `pinOutEn` and `pinOutData` in the cycle right after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busAddr | input | 3 | Register address for read and write |
| busWrData | input | WIDTH | Write value |
| busWrMask | input | WIDTH | Per-bit write enable |
| busRdData | output | WIDTH | Read result, valid the cycle after the request |
| rxBusy | input | 1 | Radio receive active |
| txBusy | input | 1 | Radio transmit active |
| pinIn | input | WIDTH | Pad input levels (asynchronous) |
| pinOutEn | output | WIDTH | Per-pin drive enable |
| pinOutData | output | WIDTH | Per-pin driven level |

## Verification
Two functions can fall in one cycle. A register write can meet a read of the same register, and a write to an activity register or the source select can meet a change in receive/transmit status. A directed case issues a read and a write to the software-level register together and expects the old value. Random traffic then repeatedly drives writes, reads and status flips in the same cycles. A bench model updates only at each clock edge and so sets the expected read value and pin level for each collision.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W     = 3;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int NUM_STATES = 4;

  localparam logic [ADDR_W-1:0] A_SRC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDLE = 3'd2;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DUP  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MAN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_PIN  = 3'd7;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                rdStrobe;
    logic [ADDR_W-1:0]   rdSel;
    logic [1:0]          actSel;
  } ctlStrobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rxBusy,
  input  logic              txBusy,
  output ctlStrobes_t       strb
);
  logic [1:0] actQ;

  // activity status is re-registered every cycle, reset or not
  always_ff @(posedge clk) begin
    actQ <= {txBusy, rxBusy};
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_wrDec
      if (g == int'(A_PIN)) begin : g_ro
        assign strb.wrSel[g] = 1'b0;
      end else begin : g_rw
        assign strb.wrSel[g] = busWrEn && (busAddr == ADDR_W'(g));
      end
    end
  endgenerate

  assign strb.rdStrobe = busRdEn;
  assign strb.rdSel    = busAddr;
  assign strb.actSel   = actQ;
endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] busWrMask,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] busRdData,
  output logic [WIDTH-1:0] pinOutEn,
  output logic [WIDTH-1:0] pinOutData
);
  logic [WIDTH-1:0] srcSel;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] manualOut;
  logic [WIDTH-1:0] stateReg [NUM_STATES];
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] rdMux;
  logic [WIDTH-1:0] activeLevel;
  logic [WIDTH-1:0] rdQ;

  function automatic logic [WIDTH-1:0] mergeBits(input logic [WIDTH-1:0] oldV,
                                                 input logic [WIDTH-1:0] newV,
                                                 input logic [WIDTH-1:0] msk);
    return (oldV & ~msk) | (newV & msk);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel    <= '0;
      dirReg    <= '0;
      manualOut <= '0;
    end else begin
      if (strb.wrSel[A_SRC]) srcSel    <= mergeBits(srcSel, busWrData, busWrMask);
      if (strb.wrSel[A_DIR]) dirReg    <= mergeBits(dirReg, busWrData, busWrMask);
      if (strb.wrSel[A_MAN]) manualOut <= mergeBits(manualOut, busWrData, busWrMask);
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_STATES; s++) begin : g_state
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stateReg[s] <= '0;
        end else if (strb.wrSel[int'(A_IDLE) + s]) begin
          stateReg[s] <= mergeBits(stateReg[s], busWrData, busWrMask);
        end
      end
    end
  endgenerate

  // two-stage synchroniser on the pad inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign activeLevel = stateReg[strb.actSel];

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_pin
      assign pinOutData[b] = srcSel[b] ? activeLevel[b] : manualOut[b];
      assign pinOutEn[b]   = dirReg[b];
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      A_SRC:  rdMux = srcSel;
      A_DIR:  rdMux = dirReg;
      A_IDLE: rdMux = stateReg[0];
      A_RX:   rdMux = stateReg[1];
      A_TX:   rdMux = stateReg[2];
      A_DUP:  rdMux = stateReg[3];
      A_MAN:  rdMux = manualOut;
      default: rdMux = syncB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.rdStrobe) begin
      rdQ <= rdMux;
    end
  end

  assign busRdData = rdQ;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWrData,
  input  logic [WIDTH-1:0]  busWrMask,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              rxBusy,
  input  logic              txBusy,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOutEn,
  output logic [WIDTH-1:0]  pinOutData
);
  ctlStrobes_t strb;

  gpio_bank_ctrl ctrl_i (
    .clk     (clk),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .rxBusy  (rxBusy),
    .txBusy  (txBusy),
    .strb    (strb)
  );

  gpio_bank_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWrData  (busWrData),
    .busWrMask  (busWrMask),
    .pinIn      (pinIn),
    .busRdData  (busRdData),
    .pinOutEn   (pinOutEn),
    .pinOutData (pinOutData)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busWrMask,
  input logic [WIDTH-1:0]  busRdData,
  input logic              rxBusy,
  input logic              txBusy,
  input logic [WIDTH-1:0]  pinOutEn,
  input logic [WIDTH-1:0]  pinOutData
);
  AST_RESET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOutEn == '0)); // R1

  AST_DIR_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_DIR) |=>
      (pinOutEn == (($past(pinOutEn) & ~$past(busWrMask)) |
                    ($past(busWrData) & $past(busWrMask))))); // R2

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrMask == '0 && $stable(rxBusy) && $stable(txBusy)) |=>
      ($stable(pinOutEn) && $stable(pinOutData))); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && $stable(rxBusy) && $stable(txBusy)) |=>
      ($stable(pinOutData) && $stable(pinOutEn))); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData)); // R7

  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_PIN && $stable(rxBusy) && $stable(txBusy)) |=>
      ($stable(pinOutEn) && $stable(pinOutData))); // R9
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  localparam int W = 11;
  localparam logic [W-1:0] FULL = 11'h7FF;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]   busAddr = '0;
  logic [W-1:0] busWrData = '0, busWrMask = '0;
  logic [W-1:0] busRdData;
  logic         rxBusy = 1'b0, txBusy = 1'b0;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOutEn, pinOutData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0] mSrc = '0, mDir = '0, mMan = '0, mS1 = '0, mS2 = '0, mRd = '0;
  logic [W-1:0] mSt [4] = '{default: '0};
  logic [1:0]   mAct = '0;

  always #4 clk = ~clk;

  gpio_bank #(.WIDTH(W)) dut_i (.*);

  function automatic logic [W-1:0] mergeExp(input logic [W-1:0] o, input logic [W-1:0] n,
                                           input logic [W-1:0] m);
    return (o & ~m) | (n & m);
  endfunction

  function automatic logic [W-1:0] readExp(input logic [2:0] a);
    case (a)
      3'd0: return mSrc;
      3'd1: return mDir;
      3'd2, 3'd3, 3'd4, 3'd5: return mSt[a - 3'd2];
      3'd6: return mMan;
      default: return mS2;
    endcase
  endfunction

  function automatic logic [W-1:0] pinExp();
    return (mSrc & mSt[mAct]) | (~mSrc & mMan);
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic step(input string tag, input logic we, input logic re, input logic [2:0] a,
                      input logic [W-1:0] d, input logic [W-1:0] m, input logic rx,
                      input logic tx, input logic [W-1:0] pin);
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d; busWrMask = m;
    rxBusy = rx; txBusy = tx; pinIn = pin;
    if (re) mRd = readExp(a);
    if (we) begin
      case (a)
        3'd0: mSrc = mergeExp(mSrc, d, m);
        3'd1: mDir = mergeExp(mDir, d, m);
        3'd2, 3'd3, 3'd4, 3'd5: mSt[a - 3'd2] = mergeExp(mSt[a - 3'd2], d, m);
        3'd6: mMan = mergeExp(mMan, d, m);
        default: ;
      endcase
    end
    mAct = {tx, rx};
    mS2 = mS1;
    mS1 = pin;
    @(negedge clk);
    check(tag, "pinOutEn", pinOutEn, mDir);
    check(tag, "pinOutData", pinOutData, pinExp());
    check(tag, "busRdData", busRdData, mRd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values on pins and every writable register
    check("R1", "pinOutEn after reset", pinOutEn, '0);
    check("R1", "pinOutData after reset", pinOutData, '0);
    for (int a = 0; a < 7; a++) begin
      step("R1 R7", 1'b0, 1'b1, 3'(a), '0, '0, 1'b0, 1'b0, '0);
      check("R1", "reset register read", busRdData, '0);
    end
    // R2 R3: partial mask on direction, then a zero mask
    step("R2 R3", 1'b1, 1'b0, 3'd1, FULL, 11'h400, 1'b0, 1'b0, '0);
    check("R3", "one bit driven", pinOutEn, 11'h400);
    step("R2", 1'b1, 1'b0, 3'd1, 11'h000, 11'h000, 1'b0, 1'b0, '0);
    check("R2", "zero mask keeps direction", pinOutEn, 11'h400);
    step("R2 R3", 1'b1, 1'b0, 3'd1, 11'h01F, 11'h0FF, 1'b0, 1'b0, '0);
    check("R2", "merged direction", pinOutEn, 11'h41F);
    // R4: software-level pin ignores activity
    step("R4 R11", 1'b1, 1'b0, 3'd6, FULL, 11'h010, 1'b0, 1'b0, '0);
    for (int k = 0; k < 4; k++) begin
      step("R4", 1'b0, 1'b0, 3'd0, '0, '0, k[0], k[1], '0);
      check("R4", "manual pin under activity", pinOutData & 11'h010, 11'h010);
    end
    // R5 R6: one activity register per state, bits 0..3 follow activity
    step("R5", 1'b1, 1'b0, 3'd2, 11'h001, FULL, 1'b0, 1'b0, '0);
    step("R5", 1'b1, 1'b0, 3'd3, 11'h002, FULL, 1'b0, 1'b0, '0);
    step("R5", 1'b1, 1'b0, 3'd4, 11'h004, FULL, 1'b0, 1'b0, '0);
    step("R5", 1'b1, 1'b0, 3'd5, 11'h008, FULL, 1'b0, 1'b0, '0);
    step("R5", 1'b1, 1'b0, 3'd0, 11'h00F, 11'h00F, 1'b0, 1'b0, '0);
    check("R5", "idle pattern", pinOutData & 11'h00F, 11'h001);
    step("R5 R6", 1'b0, 1'b0, 3'd0, '0, '0, 1'b1, 1'b0, '0);
    check("R6", "rx pattern one clock later", pinOutData & 11'h00F, 11'h002);
    step("R5 R6", 1'b0, 1'b0, 3'd0, '0, '0, 1'b0, 1'b1, '0);
    check("R5", "tx pattern", pinOutData & 11'h00F, 11'h004);
    step("R5 R6", 1'b0, 1'b0, 3'd0, '0, '0, 1'b1, 1'b1, '0);
    check("R5", "duplex pattern", pinOutData & 11'h00F, 11'h008);
    // R9: write to the readback address
    step("R9", 1'b1, 1'b0, 3'd7, FULL, FULL, 1'b1, 1'b1, '0);
    check("R9", "pins unchanged", pinOutData & 11'h00F, 11'h008);
    check("R9", "direction unchanged", pinOutEn, 11'h41F);
    // R8: readback lags pins by two clocks
    step("R8", 1'b0, 1'b0, 3'd0, '0, '0, 1'b0, 1'b0, 11'h5A5);
    step("R8", 1'b0, 1'b0, 3'd0, '0, '0, 1'b0, 1'b0, 11'h5A5);
    step("R8", 1'b0, 1'b1, 3'd7, '0, '0, 1'b0, 1'b0, 11'h000);
    check("R8", "readback two clocks late", busRdData, 11'h5A5);
    // R10: read and write collide on the software-level register
    step("R10", 1'b1, 1'b1, 3'd6, 11'h000, FULL, 1'b0, 1'b0, '0);
    check("R10", "old value returned", busRdData, 11'h010);
    step("R10", 1'b0, 1'b1, 3'd6, '0, '0, 1'b0, 1'b0, '0);
    check("R10", "new value afterwards", busRdData, 11'h000);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic rx, tx;
      rx = ($urandom % 4 == 0) ? ~rxBusy : rxBusy;
      tx = ($urandom % 4 == 0) ? ~txBusy : txBusy;
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11", 1'($urandom % 2), 1'($urandom % 2),
           3'($urandom % 8), W'($urandom), ($urandom % 5 == 0) ? FULL : W'($urandom),
           rx, tx, W'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule